// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares two divided clock streams, the reference comparison clock and the divided-down oscillator feedback, and tells a charge pump which way to push the loop filter. Both streams are sampled in the system clock domain. A rising edge on either stream arms a flag for that side. When both flags are armed they are cleared together, so a drive request lasts exactly as long as the gap between the two edges, counted in system clock cycles. When the edges coincide there is no drive. The charge-pump current sources, the bias selection and the loop filter are outside this block.

A polarity input picks which pump direction answers a leading reference edge, so one design can serve oscillators whose tuning slope has either sign. An active-low lock indicator goes low for exactly the interval in which either flag is armed. Its low time is therefore the measured phase error, and a following low-pass filter can judge how close the loop is to lock. Because the flags stay armed until the lagging edge arrives, the detector keeps steering the same way when the two frequencies differ, not just when they are out of phase. Pulling the enable low clears both flags and silences all outputs.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is asserted (rstN low) and on the first cycle after it, pumpUp and pumpDn are 0 and lockN is 1.
- R2: A rising edge means a stream is sampled 1 at a clock edge after being sampled 0 at the previous clock edge. With polarity 1 and the reference edge leading the feedback edge by k cycles (k ≥ 1), pumpUp is 1 for exactly k cycles and pumpDn stays 0.
- R3: With polarity 1 and the feedback edge leading by k cycles, pumpDn is 1 for exactly k cycles and pumpUp stays 0.
- R4: With polarity 0 the directions swap. A leading reference edge gives k cycles of pumpDn, and a leading feedback edge gives k cycles of pumpUp.
- R5: When both rising edges are sampled at the same clock edge, no pump output is driven and lockN stays 1.
- R6: lockN is 0 in exactly the cycles in which pumpUp or pumpDn is 1, so its low time equals the phase-error interval.
- R7: pumpUp and pumpDn are never 1 in the same cycle.
- R8: While enable is 0, both pump outputs are 0 and lockN is 1 from the next cycle on. Edges seen while enable is 0 leave no pending request once enable returns to 1.
- R9: If the reference stream rises again before any feedback edge arrives, the drive stays asserted without a break until the feedback edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both streams are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = detector active, 0 = outputs quiet and flags cleared |
| polarity | input | 1 | 1 = leading reference drives pumpUp, 0 = leading reference drives pumpDn |
| refPulse | input | 1 | Divided reference stream |
| fbPulse | input | 1 | Divided feedback stream |
| pumpUp | output | 1 | Request to source charge-pump current |
| pumpDn | output | 1 | Request to sink charge-pump current; both 0 means the pump is tristate |
| lockN | output | 1 | Active-low phase-error indicator |

## Verification
An armed flag that fails to clear shows up in the next cycle as a pump output stuck high while lockN stays low, and the pulse width counted against a known edge offset is too long. A missed edge set shows up as a pulse that is short by one or more cycles, or missing. A wrong polarity mapping sends the pulse to the opposite pump output. A missed clear on disable leaves a request pending when enable returns, which the first run after re-enable exposes. Each run compares the per-output cycle counts, the lockN low time and any overlap with values derived from the edge offsets, so a fault is reported within one run of a few dozen cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic armRef;
    logic armFb;
    logic clearAll;
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_edge_ctrl.sv
module pfd_edge_ctrl
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       enable,
  input  logic       refPulse,
  input  logic       fbPulse,
  output pfdStrobe_t strobe
);
  logic refPrev;
  logic fbPrev;

  // Previous samples follow the inputs even during reset, so a stream that is
  // already high when reset is released is not counted as an edge.
  always_ff @(posedge clk) begin
    refPrev <= refPulse;
    fbPrev  <= fbPulse;
  end

  always_comb begin
    strobe.armRef   = enable & refPulse & ~refPrev;
    strobe.armFb    = enable & fbPulse & ~fbPrev;
    strobe.clearAll = ~enable;
  end
endmodule

// File: rtl/pfd_flag_path.sv
module pfd_flag_path
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       polarity,
  input  pfdStrobe_t strobe,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       lockN
);
  logic refFlag;
  logic fbFlag;
  logic refNext;
  logic fbNext;

  always_comb begin
    refNext = refFlag | strobe.armRef;
    fbNext  = fbFlag | strobe.armFb;
    if (strobe.clearAll || (refNext && fbNext)) begin
      refNext = 1'b0;
      fbNext  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refFlag <= 1'b0;
      fbFlag  <= 1'b0;
    end else begin
      refFlag <= refNext;
      fbFlag  <= fbNext;
    end
  end

  assign pumpUp = polarity ? refFlag : fbFlag;
  assign pumpDn = polarity ? fbFlag : refFlag;
  assign lockN  = ~(refFlag | fbFlag);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic polarity,
  input  logic refPulse,
  input  logic fbPulse,
  output logic pumpUp,
  output logic pumpDn,
  output logic lockN
);
  pfdStrobe_t strobe;

  pfd_edge_ctrl uCtrl (
    .clk      (clk),
    .enable   (enable),
    .refPulse (refPulse),
    .fbPulse  (fbPulse),
    .strobe   (strobe)
  );

  pfd_flag_path uPath (
    .clk      (clk),
    .rstN     (rstN),
    .polarity (polarity),
    .strobe   (strobe),
    .pumpUp   (pumpUp),
    .pumpDn   (pumpDn),
    .lockN    (lockN)
  );
endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic polarity,
  input logic refPulse,
  input logic fbPulse,
  input logic pumpUp,
  input logic pumpDn,
  input logic lockN
);
  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!pumpUp && !pumpDn && lockN);
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDn));

  p_lock_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    lockN == !(pumpUp || pumpDn));

  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pumpUp && !pumpDn && lockN));

  p_coincide_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && lockN && $rose(refPulse) && $rose(fbPulse)) |=> lockN);

  p_ref_lead_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && polarity && lockN && $rose(refPulse) && !$rose(fbPulse)) |=> pumpUp);

  p_ref_lead_dn_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !polarity && lockN && $rose(refPulse) && !$rose(fbPulse)) |=> pumpDn);
endmodule

bind pfd_lock_top pfd_lock_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .polarity (polarity),
  .refPulse (refPulse),
  .fbPulse  (fbPulse),
  .pumpUp   (pumpUp),
  .pumpDn   (pumpDn),
  .lockN    (lockN)
);

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic polarity = 1'b1;
  logic refPulse = 1'b0;
  logic fbPulse = 1'b0;
  logic pumpUp, pumpDn, lockN;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pfd_lock_top uut (
    .clk(clk), .rstN(rstN), .enable(enable), .polarity(polarity),
    .refPulse(refPulse), .fbPulse(fbPulse),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .lockN(lockN)
  );

  function automatic int expUpCycles(int refAt, int fbAt, bit pol, bit en);
    int lead;
    if (!en) return 0;
    lead = pol ? (fbAt - refAt) : (refAt - fbAt);
    return (lead > 0) ? lead : 0;
  endfunction

  function automatic int expDnCycles(int refAt, int fbAt, bit pol, bit en);
    return expUpCycles(fbAt, refAt, pol, en);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Raise ref at cycle refAt and fb at cycle fbAt, then count output cycles.
  task automatic runPair(int refAt, int fbAt, bit pol, bit en, string tag);
    int upN = 0, dnN = 0, lowN = 0, both = 0;
    int span;
    span = ((refAt > fbAt) ? refAt : fbAt) + 4;
    @(negedge clk);
    polarity = pol;
    enable = en;
    for (int c = 0; c < span; c++) begin
      refPulse = (c >= refAt);
      fbPulse  = (c >= fbAt);
      @(posedge clk);
      #1;
      upN  += pumpUp;
      dnN  += pumpDn;
      lowN += !lockN;
      both += (pumpUp && pumpDn);
      @(negedge clk);
    end
    refPulse = 1'b0;
    fbPulse = 1'b0;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check({tag, " up width"}, upN, expUpCycles(refAt, fbAt, pol, en));
    check({tag, " dn width"}, dnN, expDnCycles(refAt, fbAt, pol, en));
    check("R6 lock low time", lowN,
          expUpCycles(refAt, fbAt, pol, en) + expDnCycles(refAt, fbAt, pol, en));
    check("R7 overlap", both, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    int upN;
    int lowN;
    seed = $urandom(32'h5a17);
    repeat (3) @(negedge clk);
    check("R1 up in reset", pumpUp, 0);
    check("R1 dn in reset", pumpDn, 0);
    check("R1 lockN in reset", lockN, 1);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 lockN after reset", lockN, 1);
    @(negedge clk);

    runPair(0, 5, 1'b1, 1'b1, "R2 ref leads");
    runPair(0, 1, 1'b1, 1'b1, "R2 ref leads by one");
    runPair(7, 0, 1'b1, 1'b1, "R3 fb leads");
    runPair(0, 6, 1'b0, 1'b0 | 1'b1, "R4 pol0 ref leads");
    runPair(4, 0, 1'b0, 1'b1, "R4 pol0 fb leads");
    runPair(3, 3, 1'b1, 1'b1, "R5 coincident");
    runPair(0, 9, 1'b1, 1'b0, "R8 disabled");

    // R8: edges while disabled leave nothing pending after re-enable.
    @(negedge clk);
    enable = 1'b0;
    refPulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    lowN = 0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk);
      #1;
      lowN += !lockN;
      @(negedge clk);
    end
    check("R8 no pending after re-enable", lowN, 0);
    refPulse = 1'b0;
    repeat (2) @(negedge clk);

    // R9: two reference edges before the feedback edge; drive holds throughout.
    polarity = 1'b1;
    upN = 0;
    for (int c = 0; c < 12; c++) begin
      refPulse = (c < 2) || (c >= 4);
      fbPulse  = (c >= 8);
      @(posedge clk);
      #1;
      upN += pumpUp;
      @(negedge clk);
    end
    check("R9 held drive width", upN, 8);
    refPulse = 1'b0;
    fbPulse = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      int ra, fa;
      bit pol;
      ra = $urandom_range(0, 20);
      fa = $urandom_range(0, 20);
      pol = $urandom_range(0, 1);
      runPair(ra, fa, pol, 1'b1, "R2 R3 R4 random");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule